// File: doc/BRIEF.md
# Parallel Flash Boot Sequencer

This block runs once after reset and decides where a 16-bit processor begins fetching code. While reset is held it samples a mode strap. After reset it either points the processor straight at external program memory, or it runs an internal load path. The internal path first looks at a host boot request. If no request is present, it reads a selection byte from the top of I/O space and, for the byte-wide parallel mode, copies a boot table from flash into program RAM.

The boot table sits in flash at a base address taken from the selection byte. Each 16-bit item is made of two consecutive flash bytes, high byte first. The table holds, in order, a destination address, a word count and that many program words. The words land in program RAM starting at the destination address. The sequencer then raises its done flag with the destination as the start address.

A small decoder drives the flash chip enable. The enable is active for any data-space access, and for I/O accesses only inside the upper quarter of the address space. Every flash access holds its strobe for a configurable number of wait cycles.

Top module: `pflash_boot_seq`

## Requirements
- R1: If the mode strap is 1 during reset, the block makes no flash access and no RAM write. It raises done with start address 0xFF80 and the external flag set to 1.
- R2: If the strap is 0 and the boot request is 1, the block raises the unsupported flag. It never raises done and makes no flash access.
- R3: Otherwise the first flash access is a single I/O-space read (I/O strobe low, data strobe high) at address 0xFFFF.
- R4: If bits [1:0] of the selection byte are anything other than 01, the block raises the mode error flag. It makes no further access or write and never raises done.
- R5: In parallel mode, all table reads are data-space reads. They start at address {sel[7:2], 10'b0} and step by one per byte.
- R6: Each table item is formed as {first byte, second byte}. The table layout is destination, count, words. Program word k is written to RAM address destination+k, one write per word, in order.
- R7: Done rises on the same edge as the last RAM write. The start address then equals the destination and the external flag is 0. Done and the start address then stay stable.
- R8: A word count of zero raises done with the destination as start address and makes no RAM write.
- R9: Each flash access holds its strobe low for exactly wait_cfg_i+1 clock cycles.
- R10: The flash enable is low whenever the data strobe is low, or the I/O strobe is low with address bits 15 and 14 both 1. Otherwise it is high.
- R11: Flash address bit 16 is always 0.
- R12: During and right after reset, both strobes are high and pram_we_o, done_o, mode_err_o and unsup_o are all 0. The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_strap_i | input | 1 | Boot mode strap, sampled while rst is high |
| boot_req_i | input | 1 | Host boot request, active high |
| wait_cfg_i | input | WAIT_W | Wait cycles added to each flash access |
| flash_addr_o | output | 17 | Flash byte address, bit 16 held at 0 |
| flash_data_i | input | 8 | Flash read data |
| data_strb_n_o | output | 1 | Data-space read strobe, active low |
| io_strb_n_o | output | 1 | I/O-space read strobe, active low |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| pram_we_o | output | 1 | Program RAM write pulse |
| pram_addr_o | output | 16 | Program RAM write address |
| pram_data_o | output | 16 | Program RAM write data |
| start_addr_o | output | 16 | Address where execution begins |
| start_ext_o | output | 1 | 1 when the start address is in external program memory |
| done_o | output | 1 | Boot finished, start address valid |
| mode_err_o | output | 1 | Selection byte named an unsupported mode |
| unsup_o | output | 1 | Host-port load requested, not supported |

## Verification
The hardest case to reach is the edge between reading the count item and deciding whether to read any program word. A zero count has to stop the sequencer before the next byte fetch starts. The bench reaches it by building a table whose count is zero, with a base at the very top of flash and a large wait setting. Any stray extra read then shows up as an access that the reference model did not expect. Selection bytes whose top six bits differ are used to move the table base around. The bench's flash model answers only while the chip enable is low, so a wrong enable decode turns the selection read into a mode error.

// File: rtl/pboot_pkg.sv
package pboot_pkg;

    localparam int ADDR_W = 16;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int BASE_SHIFT = 10;
    localparam logic [1:0] PAR8_CODE = 2'b01;

    typedef enum logic [3:0] {
        ST_DECIDE,
        ST_SEL,
        ST_DEST,
        ST_CNT,
        ST_COPY,
        ST_DONE,
        ST_ERR,
        ST_UNSUP
    } boot_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
    } fetch_req_t;

    function automatic logic [ADDR_W-1:0] table_base(input logic [BYTE_W-1:0] sel);
        return {sel[BYTE_W-1:2], {BASE_SHIFT{1'b0}}};
    endfunction

    function automatic logic is_par8(input logic [BYTE_W-1:0] sel);
        return sel[1:0] == PAR8_CODE;
    endfunction

endpackage

// File: rtl/pboot_byte_fetch.sv
module pboot_byte_fetch
    import pboot_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  fetch_req_t          req_info_i,
    input  logic [WAIT_W-1:0]   wait_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                data_strb_n_o,
    output logic                io_strb_n_o,
    output logic [BYTE_W-1:0]   byte_o,
    output logic                vld_o
);
    logic              act_q;
    logic              io_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] lim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            io_q   <= 1'b0;
            cnt_q  <= '0;
            lim_q  <= '0;
            addr_q <= '0;
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (!act_q) begin
                if (req_i) begin
                    act_q  <= 1'b1;
                    cnt_q  <= '0;
                    lim_q  <= wait_i;
                    addr_q <= req_info_i.addr;
                    io_q   <= req_info_i.io;
                end
            end else if (cnt_q == lim_q) begin
                byte_q <= data_i;
                vld_q  <= 1'b1;
                act_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign addr_o        = addr_q;
    assign data_strb_n_o = !(act_q && !io_q);
    assign io_strb_n_o   = !(act_q && io_q);
    assign byte_o        = byte_q;
    assign vld_o         = vld_q;

endmodule

// File: rtl/pboot_word_join.sv
module pboot_word_join
    import pboot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic [BYTE_W-1:0]   byte_i,
    input  logic                vld_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                wvld_o
);
    logic              second_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
            hi_q     <= '0;
        end else if (clr_i) begin
            second_q <= 1'b0;
        end else if (vld_i) begin
            if (!second_q) hi_q <= byte_i;
            second_q <= !second_q;
        end
    end

    assign word_o = {hi_q, byte_i};
    assign wvld_o = vld_i && second_q && !clr_i;

endmodule

// File: rtl/pboot_ce_decode.sv
module pboot_ce_decode
    import pboot_pkg::*;
(
    input  logic              data_strb_n_i,
    input  logic              io_strb_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ce_n_o
);
    logic io_window;

    always_comb begin
        io_window = !io_strb_n_i && (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
        ce_n_o    = !(!data_strb_n_i || io_window);
    end

endmodule

// File: rtl/pflash_boot_seq.sv
module pflash_boot_seq
    import pboot_pkg::*;
#(
    parameter int              WAIT_W   = 4,
    parameter logic [15:0]     BOOT_VEC = 16'hFF80,
    parameter logic [15:0]     SEL_ADDR = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_strap_i,
    input  logic              boot_req_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    output logic [16:0]       flash_addr_o,
    input  logic [7:0]        flash_data_i,
    output logic              data_strb_n_o,
    output logic              io_strb_n_o,
    output logic              flash_ce_n_o,
    output logic              pram_we_o,
    output logic [15:0]       pram_addr_o,
    output logic [15:0]       pram_data_o,
    output logic [15:0]       start_addr_o,
    output logic              start_ext_o,
    output logic              done_o,
    output logic              mode_err_o,
    output logic              unsup_o
);
    boot_st_e          st_q;
    logic              strap_q;
    logic              pend_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] dest_q;
    logic [ADDR_W-1:0] widx_q;
    logic [WORD_W-1:0] left_q;

    logic              fetch_req;
    fetch_req_t        fetch_info;
    logic [ADDR_W-1:0] fetch_addr;
    logic [BYTE_W-1:0] fetch_byte;
    logic              fetch_vld;
    logic [WORD_W-1:0] item;
    logic              item_vld;
    logic              reading;

    always_comb begin
        reading = (st_q == ST_SEL) || (st_q == ST_DEST) ||
                  (st_q == ST_CNT) || (st_q == ST_COPY);
        fetch_req = reading && !pend_q;
        fetch_info.io   = (st_q == ST_SEL);
        fetch_info.addr = (st_q == ST_SEL) ? SEL_ADDR : ptr_q;
    end

    pboot_byte_fetch #(.WAIT_W(WAIT_W)) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .req_i         (fetch_req),
        .req_info_i    (fetch_info),
        .wait_i        (wait_cfg_i),
        .data_i        (flash_data_i),
        .addr_o        (fetch_addr),
        .data_strb_n_o (data_strb_n_o),
        .io_strb_n_o   (io_strb_n_o),
        .byte_o        (fetch_byte),
        .vld_o         (fetch_vld)
    );

    pboot_word_join u_join (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (st_q == ST_SEL),
        .byte_i (fetch_byte),
        .vld_i  (fetch_vld),
        .word_o (item),
        .wvld_o (item_vld)
    );

    pboot_ce_decode u_ce (
        .data_strb_n_i (data_strb_n_o),
        .io_strb_n_i   (io_strb_n_o),
        .addr_i        (fetch_addr),
        .ce_n_o        (flash_ce_n_o)
    );

    assign flash_addr_o = {1'b0, fetch_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_DECIDE;
            strap_q      <= mode_strap_i;
            pend_q       <= 1'b0;
            ptr_q        <= '0;
            dest_q       <= '0;
            widx_q       <= '0;
            left_q       <= '0;
            pram_we_o    <= 1'b0;
            pram_addr_o  <= '0;
            pram_data_o  <= '0;
            start_addr_o <= '0;
            start_ext_o  <= 1'b0;
            done_o       <= 1'b0;
            mode_err_o   <= 1'b0;
            unsup_o      <= 1'b0;
        end else begin
            pram_we_o <= 1'b0;
            if (fetch_req)      pend_q <= 1'b1;
            else if (fetch_vld) pend_q <= 1'b0;
            if (fetch_vld && st_q != ST_SEL) ptr_q <= ptr_q + 1'b1;

            case (st_q)
                ST_DECIDE: begin
                    if (strap_q) begin
                        start_addr_o <= BOOT_VEC;
                        start_ext_o  <= 1'b1;
                        done_o       <= 1'b1;
                        st_q         <= ST_DONE;
                    end else if (boot_req_i) begin
                        unsup_o <= 1'b1;
                        st_q    <= ST_UNSUP;
                    end else begin
                        st_q <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (fetch_vld) begin
                        if (is_par8(fetch_byte)) begin
                            ptr_q <= table_base(fetch_byte);
                            st_q  <= ST_DEST;
                        end else begin
                            mode_err_o <= 1'b1;
                            st_q       <= ST_ERR;
                        end
                    end
                end
                ST_DEST: begin
                    if (item_vld) begin
                        dest_q <= item;
                        widx_q <= item;
                        st_q   <= ST_CNT;
                    end
                end
                ST_CNT: begin
                    if (item_vld) begin
                        if (item == '0) begin
                            start_addr_o <= dest_q;
                            done_o       <= 1'b1;
                            st_q         <= ST_DONE;
                        end else begin
                            left_q <= item;
                            st_q   <= ST_COPY;
                        end
                    end
                end
                ST_COPY: begin
                    if (item_vld) begin
                        pram_we_o   <= 1'b1;
                        pram_addr_o <= widx_q;
                        pram_data_o <= item;
                        widx_q      <= widx_q + 1'b1;
                        left_q      <= left_q - 1'b1;
                        if (left_q == 16'd1) begin
                            start_addr_o <= dest_q;
                            done_o       <= 1'b1;
                            st_q         <= ST_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pboot_checker.sv
module pboot_checker (
    input logic        clk,
    input logic        rst,
    input logic [16:0] flash_addr_o,
    input logic        data_strb_n_o,
    input logic        io_strb_n_o,
    input logic        flash_ce_n_o,
    input logic        pram_we_o,
    input logic [15:0] start_addr_o,
    input logic        start_ext_o,
    input logic        done_o,
    input logic        mode_err_o,
    input logic        unsup_o
);
    a_r10_ce_on_access: assert property (@(posedge clk) disable iff (rst)
        (!data_strb_n_o || (!io_strb_n_o && flash_addr_o[15:14] == 2'b11)) |-> !flash_ce_n_o);

    a_r10_ce_idle: assert property (@(posedge clk) disable iff (rst)
        (data_strb_n_o && io_strb_n_o) |-> flash_ce_n_o);

    a_r3_io_top: assert property (@(posedge clk) disable iff (rst)
        !io_strb_n_o |-> flash_addr_o[15:0] == 16'hFFFF);

    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!data_strb_n_o && !io_strb_n_o));

    a_r2_unsup_quiet: assert property (@(posedge clk) disable iff (rst)
        unsup_o |-> (data_strb_n_o && io_strb_n_o && !done_o && !pram_we_o));

    a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> (data_strb_n_o && io_strb_n_o && !done_o && !pram_we_o));

    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(start_addr_o) && $stable(start_ext_o)));

    a_r1_ext_vector: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_ext_o) |-> start_addr_o == 16'hFF80);

    a_r11_top_bit: assert property (@(posedge clk) disable iff (rst)
        !flash_ce_n_o |-> !flash_addr_o[16]);
endmodule

bind pflash_boot_seq pboot_checker u_pboot_chk (
    .clk           (clk),
    .rst           (rst),
    .flash_addr_o  (flash_addr_o),
    .data_strb_n_o (data_strb_n_o),
    .io_strb_n_o   (io_strb_n_o),
    .flash_ce_n_o  (flash_ce_n_o),
    .pram_we_o     (pram_we_o),
    .start_addr_o  (start_addr_o),
    .start_ext_o   (start_ext_o),
    .done_o        (done_o),
    .mode_err_o    (mode_err_o),
    .unsup_o       (unsup_o)
);

// File: tb/tb_pflash_boot_seq.sv
`timescale 1ns/100ps
module tb_pflash_boot_seq;
    localparam int WAIT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_strap = 1'b0;
    logic boot_req = 1'b0;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic [16:0] flash_addr;
    logic [7:0]  flash_data = 8'hFF;
    logic data_strb_n, io_strb_n, flash_ce_n;
    logic pram_we;
    logic [15:0] pram_addr, pram_data, start_addr;
    logic start_ext, done, mode_err, unsup;

    always #2.5 clk = ~clk;

    pflash_boot_seq #(.WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst(rst), .mode_strap_i(mode_strap), .boot_req_i(boot_req),
        .wait_cfg_i(wait_cfg), .flash_addr_o(flash_addr), .flash_data_i(flash_data),
        .data_strb_n_o(data_strb_n), .io_strb_n_o(io_strb_n), .flash_ce_n_o(flash_ce_n),
        .pram_we_o(pram_we), .pram_addr_o(pram_addr), .pram_data_o(pram_data),
        .start_addr_o(start_addr), .start_ext_o(start_ext), .done_o(done),
        .mode_err_o(mode_err), .unsup_o(unsup)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  fmem [int];
    logic [16:0] exp_acc [$];
    logic [31:0] exp_wr  [$];
    int          exp_len;
    bit          mon_en = 1'b0;
    int          run_len = 0;
    logic [15:0] run_addr;
    logic        run_io;

    function automatic logic [7:0] fread(input int a);
        return fmem.exists(a) ? fmem[a] : 8'hFF;
    endfunction

    always @(negedge clk) flash_data <= flash_ce_n ? 8'hFF : fread(int'(flash_addr));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mon_en) begin
            logic exp_ce;
            exp_ce = !(!data_strb_n || (!io_strb_n && flash_addr[15] && flash_addr[14]));
            check(flash_ce_n == exp_ce, "R10", "flash enable", 32'(flash_ce_n), 32'(exp_ce));
            check(flash_addr[16] == 1'b0, "R11", "address bit 16", 32'(flash_addr[16]), 32'd0);
            check(!(!data_strb_n && !io_strb_n), "R12", "both strobes low",
                  {30'd0, data_strb_n, io_strb_n}, 32'd3);
            if (!data_strb_n || !io_strb_n) begin
                if (run_len == 0) begin
                    run_addr = flash_addr[15:0];
                    run_io   = !io_strb_n;
                end
                run_len++;
            end else if (run_len > 0) begin
                if (exp_acc.size() == 0) begin
                    check(1'b0, run_io ? "R3" : "R5", "unexpected access",
                          {15'd0, run_io, run_addr}, 32'hFFFF_FFFF);
                end else begin
                    logic [16:0] e;
                    e = exp_acc.pop_front();
                    check({run_io, run_addr} == e, e[16] ? "R3" : "R5", "access io/addr",
                          {15'd0, run_io, run_addr}, {15'd0, e});
                    check(run_len == exp_len, "R9", "strobe length",
                          32'(run_len), 32'(exp_len));
                end
                run_len = 0;
            end
            if (pram_we) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", {pram_addr, pram_data}, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] w;
                    w = exp_wr.pop_front();
                    check({pram_addr, pram_data} == w, "R6", "ram write", {pram_addr, pram_data}, w);
                    if (exp_wr.size() == 0)
                        check(done == 1'b1, "R7", "done with last write", 32'(done), 32'd1);
                end
            end
        end
    end

    task automatic scenario(input bit strap, input bit req, input logic [7:0] sel,
                            input logic [15:0] dest, input int cnt, input int ws, input int seed);
        logic [15:0] base;
        bit          e_done, e_ext, e_err, e_uns;
        logic [15:0] e_start;
        int          limit;
        mon_en = 1'b0;
        fmem.delete();
        exp_acc.delete();
        exp_wr.delete();
        run_len = 0;
        exp_len = ws + 1;
        e_done = 0; e_ext = 0; e_err = 0; e_uns = 0; e_start = 16'h0000;
        fmem[32'h0FFFF] = sel;
        base = {sel[7:2], 10'b0};
        if (strap) begin
            e_done = 1; e_ext = 1; e_start = 16'hFF80;
        end else if (req) begin
            e_uns = 1;
        end else begin
            exp_acc.push_back({1'b1, 16'hFFFF});
            if (sel[1:0] != 2'b01) begin
                e_err = 1;
            end else begin
                logic [15:0] items [$];
                items.push_back(dest);
                items.push_back(16'(cnt));
                for (int k = 0; k < cnt; k++) begin
                    logic [15:0] w;
                    w = 16'h5A3C ^ 16'(seed * 16'h0111) ^ 16'(k * 16'h0203);
                    items.push_back(w);
                    exp_wr.push_back({16'(dest + 16'(k)), w});
                end
                for (int i = 0; i < items.size(); i++) begin
                    logic [15:0] a;
                    a = base + 16'(2 * i);
                    fmem[int'(a)]       = items[i][15:8];
                    fmem[int'(a + 1'b1)] = items[i][7:0];
                    exp_acc.push_back({1'b0, a});
                    exp_acc.push_back({1'b0, 16'(a + 1'b1)});
                end
                e_done = 1; e_start = dest;
            end
        end
        @(posedge clk); #1;
        rst = 1'b1; mode_strap = strap; boot_req = req; wait_cfg = WAIT_W'(ws);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(data_strb_n && io_strb_n, "R12", "strobes in reset", {30'd0, data_strb_n, io_strb_n}, 32'd3);
        check({pram_we, done, mode_err, unsup} == 4'd0, "R12", "flags in reset",
              {28'd0, pram_we, done, mode_err, unsup}, 32'd0);
        @(posedge clk); #1;
        rst = 1'b0; mon_en = 1'b1;
        limit = 0;
        while (!(done || mode_err || unsup) && limit < 4000) begin
            @(posedge clk); limit++;
        end
        repeat (4 * ws + 40) @(posedge clk);
        @(negedge clk);
        check(done == e_done, strap ? "R1" : (cnt == 0 ? "R8" : "R7"), "done", 32'(done), 32'(e_done));
        check(start_addr == e_start, strap ? "R1" : (cnt == 0 ? "R8" : "R7"), "start address",
              32'(start_addr), 32'(e_start));
        check(start_ext == e_ext, "R1", "external flag", 32'(start_ext), 32'(e_ext));
        check(mode_err == e_err, "R4", "mode error", 32'(mode_err), 32'(e_err));
        check(unsup == e_uns, "R2", "unsupported flag", 32'(unsup), 32'(e_uns));
        check(exp_acc.size() == 0, "R5", "missing accesses", 32'(exp_acc.size()), 32'd0);
        check(exp_wr.size() == 0, "R6", "missing writes", 32'(exp_wr.size()), 32'd0);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        scenario(1'b1, 1'b0, 8'h11, 16'h0000, 0, 1, 0);   // R1 strap high
        scenario(1'b0, 1'b1, 8'h11, 16'h0000, 0, 1, 0);   // R2 host request
        scenario(1'b0, 1'b0, 8'h13, 16'h0000, 0, 2, 0);   // R4 mode 11
        scenario(1'b0, 1'b0, 8'hF0, 16'h0000, 0, 0, 0);   // R4 mode 00
        scenario(1'b0, 1'b0, 8'h11, 16'h0200, 3, 0, 1);   // R5 R6 R7 base 0x1000
        scenario(1'b0, 1'b0, 8'hFD, 16'h1234, 0, 5, 2);   // R8 zero count, top base
        scenario(1'b0, 1'b0, 8'h0D, 16'h3000, 5, 2, 3);   // R6 R9 base 0x0C00
        scenario(1'b0, 1'b0, 8'h81, 16'hFFFD, 2, 15, 4);  // R9 longest wait
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule